// File: doc/BRIEF.md
# DDR2 Burst Interrupt Checker

This block is a passive monitor for a DDR2 controller's command stream after decode. Each clock it accepts one command code and a bank address. It reports any column command that cuts short a burst in a way the memory does not allow. It also reports any precharge that comes too soon after the last read or write to that bank. It drives nothing back into the stream. It is meant for simulation and for on-chip sanity monitoring.

The checker keeps one burst context for the whole device. A burst occupies the bus for half the programmed burst length, counted in clocks. Interrupts are legal only with a burst length of eight, only by a command of the same direction, and only exactly two clocks after the command being cut short. A burst opened with auto-precharge may never be cut short. Each bank also has a precharge timer. The timer is sized from the programmed burst length, not from the burst that actually ran, so an interrupted burst still holds its bank for the full programmed time. Burst length, additive latency, write latency and write recovery are captured while reset is asserted.

Each finding appears on the clock after the offending command. It is reported as a one-cycle flag vector, a valid pulse, a 3-bit code and a cycle stamp. A sticky copy of each flag is held until the next reset.

Top module: `ddr2_burst_guard`

## Requirements
- R1: The command encoding is 0 idle, 1 read, 2 read with auto-precharge, 3 write, 4 write with auto-precharge, 5 precharge. Codes 6 and 7 behave as idle. All results for the command sampled at one rising edge are visible from that edge until the next one.
- R2: With burst length four, a read or write arriving while a burst is active sets flag bit 1 and code 2. An auto-precharge burst is excluded; R3 covers it.
- R3: Any read or write arriving during a burst that was opened by a command with auto-precharge sets flag bit 0 and code 1, at either burst length.
- R4: With burst length eight, two cases set flag bit 2 and code 3. The first is a command of the opposite direction arriving during a burst without auto-precharge. The second is a precharge arriving during any active burst.
- R5: With burst length eight, a same-direction command during a burst without auto-precharge sets flag bit 3 and code 4 unless it arrives exactly two clocks after the previous read or write. The two-clock case is legal, with or without auto-precharge, whatever its bank.
- R6: A burst stays active for half the burst length in clocks after each read or write, whether that command was legal or not. A read or write arriving at or after that distance is not an interrupt. Every read or write restarts the window.
- R7: A precharge to a bank sooner than AL plus half the burst length clocks after a read to that bank sets flag bit 4 and code 5. The programmed burst length is used even when the read was interrupted.
- R8: A precharge to a bank sooner than WL plus half the burst length plus write recovery clocks after a write to that bank sets flag bit 4 and code 5. A bank's timer is never shortened by a later command.
- R9: The valid output pulses with any flag. When several flags fire together, the code is one plus the index of the lowest set flag bit. The stamp gives the cycle number of the offending command, counted from 0 at the first clock after reset is released.
- R10: Reset clears the flags, the sticky flags, the code, the stamp and all timers. Sticky bits hold until reset. Configuration inputs take effect only while reset is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low; configuration is captured while it is low |
| cmd_i | input | 3 | Decoded command code |
| bank_i | input | BANK_W | Bank address of the command |
| cfg_bl8_i | input | 1 | 1 selects burst length eight, 0 selects four |
| cfg_al_i | input | AL_W | Additive latency in clocks |
| cfg_wl_i | input | WL_W | Write latency in clocks |
| cfg_twr_i | input | TWR_W | Write recovery in clocks |
| viol_valid_o | output | 1 | Pulses for one cycle when any violation is reported |
| viol_flags_o | output | 5 | One-cycle violation flags: bit0 auto-precharge burst cut short, bit1 interrupt with burst length four, bit2 wrong command type, bit3 wrong offset, bit4 early precharge |
| viol_sticky_o | output | 5 | Accumulated flags, held until reset |
| err_code_o | output | 3 | Code of the highest-priority flag, 0 when no flag is set |
| err_stamp_o | output | STAMP_W | Cycle number of the latest offending command |

## Verification
The properties assume that cmd_i is a defined value on every clock outside reset. They also assume that reset is held for at least one clock before checking starts, so that the registered flags start cleared. The stimulus changes inputs only on the falling edge and holds reset for three clocks. It uses every command code, including the two spare ones, and changes the configuration pins only where it sets out to show that they are ignored outside reset. With those inputs, each flag can be traced to the command one edge earlier, which is the relation the properties rely on.

// File: rtl/ddr2_bg_pkg.sv
package ddr2_bg_pkg;
   localparam logic [2:0] CMD_NOP = 3'd0;
   localparam logic [2:0] CMD_RD  = 3'd1;
   localparam logic [2:0] CMD_RDA = 3'd2;
   localparam logic [2:0] CMD_WR  = 3'd3;
   localparam logic [2:0] CMD_WRA = 3'd4;
   localparam logic [2:0] CMD_PRE = 3'd5;

   // Violation vector bit positions; lower index wins the error code
   localparam int V_AP    = 0;
   localparam int V_BL4   = 1;
   localparam int V_TYPE  = 2;
   localparam int V_OFS   = 3;
   localparam int V_EARLY = 4;
   localparam int NUM_VIOL = 5;
   localparam int CODE_W   = $clog2(NUM_VIOL + 1);

   localparam int BL4_HALF  = 2;
   localparam int BL8_HALF  = 4;
   localparam int LEGAL_GAP = 2;
   localparam int REM_W     = $clog2(BL8_HALF);

   typedef logic [NUM_VIOL-1:0] viol_vec_t;

   function automatic logic is_col(input logic [2:0] c);
      return (c == CMD_RD) || (c == CMD_RDA) || (c == CMD_WR) || (c == CMD_WRA);
   endfunction

   function automatic logic is_write(input logic [2:0] c);
      return (c == CMD_WR) || (c == CMD_WRA);
   endfunction
endpackage

// File: rtl/ddr2_bg_burst_track.sv
module ddr2_bg_burst_track
   import ddr2_bg_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] cmd_i,
   input  logic       bl8_i,
   output logic       v_ap_o,
   output logic       v_bl4_o,
   output logic       v_type_o,
   output logic       v_ofs_o
);
   localparam logic [REM_W-1:0] LOAD_BL8 = REM_W'(BL8_HALF - 1);
   localparam logic [REM_W-1:0] LOAD_BL4 = REM_W'(BL4_HALF - 1);
   localparam logic [REM_W-1:0] OFS_REM  = REM_W'(BL8_HALF - LEGAL_GAP);

   logic [REM_W-1:0] rem_q;
   logic             wr_q;
   logic             ap_q;
   logic             col, wr, ap, pre, busy, same_dir;

   always_comb begin
      col      = is_col(cmd_i);
      wr       = is_write(cmd_i);
      ap       = (cmd_i == CMD_RDA) || (cmd_i == CMD_WRA);
      pre      = (cmd_i == CMD_PRE);
      busy     = (rem_q != '0);
      same_dir = (wr == wr_q);
      v_ap_o   = busy && ap_q && col;
      v_bl4_o  = busy && !bl8_i && !ap_q && col;
      v_type_o = busy && bl8_i && ((col && !ap_q && !same_dir) || pre);
      v_ofs_o  = busy && bl8_i && col && !ap_q && same_dir && (rem_q != OFS_REM);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rem_q <= '0;
         wr_q  <= 1'b0;
         ap_q  <= 1'b0;
      end else if (col) begin
         rem_q <= bl8_i ? LOAD_BL8 : LOAD_BL4;
         wr_q  <= wr;
         ap_q  <= ap;
      end else if (busy) begin
         rem_q <= rem_q - REM_W'(1);
      end
   end
endmodule

// File: rtl/ddr2_bg_bank_timer.sv
module ddr2_bg_bank_timer
   import ddr2_bg_pkg::*;
#(
   parameter int BANK_W = 2,
   parameter int AL_W   = 3,
   parameter int WL_W   = 3,
   parameter int TWR_W  = 3,
   parameter int CNT_W  = 5
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        cmd_i,
   input  logic [BANK_W-1:0] bank_i,
   input  logic              bl8_i,
   input  logic [AL_W-1:0]   al_i,
   input  logic [WL_W-1:0]   wl_i,
   input  logic [TWR_W-1:0]  twr_i,
   output logic              early_o
);
   localparam int NUM_BANKS = 1 << BANK_W;

   logic [CNT_W-1:0]     half, hold;
   logic [NUM_BANKS-1:0] held;

   always_comb begin
      half = bl8_i ? CNT_W'(BL8_HALF) : CNT_W'(BL4_HALF);
      if (is_write(cmd_i))
         hold = CNT_W'(wl_i) + half + CNT_W'(twr_i) - CNT_W'(1);
      else
         hold = CNT_W'(al_i) + half - CNT_W'(1);
   end

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic [CNT_W-1:0] cnt_q, dec;
      assign dec = cnt_q - CNT_W'(cnt_q != '0);
      always_ff @(posedge clk) begin
         if (!rst_n)
            cnt_q <= '0;
         else if (is_col(cmd_i) && (bank_i == BANK_W'(b)))
            cnt_q <= (dec > hold) ? dec : hold;
         else
            cnt_q <= dec;
      end
      assign held[b] = (cnt_q != '0);
   end

   assign early_o = (cmd_i == CMD_PRE) && held[bank_i];
endmodule

// File: rtl/ddr2_bg_report.sv
module ddr2_bg_report
   import ddr2_bg_pkg::*;
#(
   parameter int STAMP_W = 16
)(
   input  logic               clk,
   input  logic               rst_n,
   input  viol_vec_t          viol_i,
   output logic               valid_o,
   output viol_vec_t          flags_o,
   output viol_vec_t          sticky_o,
   output logic [CODE_W-1:0]  code_o,
   output logic [STAMP_W-1:0] stamp_o
);
   logic [STAMP_W-1:0] cyc_q;
   logic [CODE_W-1:0]  code_n;

   always_comb begin
      code_n = '0;
      for (int i = NUM_VIOL - 1; i >= 0; i--)
         if (viol_i[i]) code_n = CODE_W'(i + 1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cyc_q    <= '0;
         valid_o  <= 1'b0;
         flags_o  <= '0;
         sticky_o <= '0;
         code_o   <= '0;
         stamp_o  <= '0;
      end else begin
         cyc_q    <= cyc_q + STAMP_W'(1);
         valid_o  <= |viol_i;
         flags_o  <= viol_i;
         sticky_o <= sticky_o | viol_i;
         code_o   <= code_n;
         if (|viol_i) stamp_o <= cyc_q;
      end
   end
endmodule

// File: rtl/ddr2_burst_guard.sv
module ddr2_burst_guard
   import ddr2_bg_pkg::*;
#(
   parameter int BANK_W  = 2,
   parameter int AL_W    = 3,
   parameter int WL_W    = 3,
   parameter int TWR_W   = 3,
   parameter int STAMP_W = 16
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic [2:0]         cmd_i,
   input  logic [BANK_W-1:0]  bank_i,
   input  logic               cfg_bl8_i,
   input  logic [AL_W-1:0]    cfg_al_i,
   input  logic [WL_W-1:0]    cfg_wl_i,
   input  logic [TWR_W-1:0]   cfg_twr_i,
   output logic               viol_valid_o,
   output logic [4:0]         viol_flags_o,
   output logic [4:0]         viol_sticky_o,
   output logic [2:0]         err_code_o,
   output logic [STAMP_W-1:0] err_stamp_o
);
   localparam int CNT_W = $clog2((1 << AL_W) + (1 << WL_W) + (1 << TWR_W) + BL8_HALF);

   if (BANK_W < 1 || BANK_W > 4) begin : g_bad_bank
      $error("BANK_W must be 1..4");
   end
   if (AL_W < 1 || WL_W < 1 || TWR_W < 1) begin : g_bad_lat
      $error("latency widths must be at least 1");
   end
   if (STAMP_W < 4) begin : g_bad_stamp
      $error("STAMP_W must be at least 4");
   end
   if (NUM_VIOL != 5 || CODE_W != 3) begin : g_bad_pkg
      $error("flag and code widths disagree with the port list");
   end

   logic             bl8_q;
   logic [AL_W-1:0]  al_q;
   logic [WL_W-1:0]  wl_q;
   logic [TWR_W-1:0] twr_q;
   viol_vec_t        viol;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bl8_q <= cfg_bl8_i;
         al_q  <= cfg_al_i;
         wl_q  <= cfg_wl_i;
         twr_q <= cfg_twr_i;
      end
   end

   ddr2_bg_burst_track u_burst (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd_i    (cmd_i),
      .bl8_i    (bl8_q),
      .v_ap_o   (viol[V_AP]),
      .v_bl4_o  (viol[V_BL4]),
      .v_type_o (viol[V_TYPE]),
      .v_ofs_o  (viol[V_OFS])
   );

   ddr2_bg_bank_timer #(
      .BANK_W (BANK_W),
      .AL_W   (AL_W),
      .WL_W   (WL_W),
      .TWR_W  (TWR_W),
      .CNT_W  (CNT_W)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .cmd_i   (cmd_i),
      .bank_i  (bank_i),
      .bl8_i   (bl8_q),
      .al_i    (al_q),
      .wl_i    (wl_q),
      .twr_i   (twr_q),
      .early_o (viol[V_EARLY])
   );

   ddr2_bg_report #(
      .STAMP_W (STAMP_W)
   ) u_report (
      .clk      (clk),
      .rst_n    (rst_n),
      .viol_i   (viol),
      .valid_o  (viol_valid_o),
      .flags_o  (viol_flags_o),
      .sticky_o (viol_sticky_o),
      .code_o   (err_code_o),
      .stamp_o  (err_stamp_o)
   );
endmodule

// File: rtl/ddr2_bg_checker.sv
module ddr2_bg_checker (
   input logic       clk,
   input logic       rst_n,
   input logic [2:0] cmd_i,
   input logic       viol_valid_o,
   input logic [4:0] viol_flags_o,
   input logic [4:0] viol_sticky_o,
   input logic [2:0] err_code_o
);
   // R10: sticky bits never clear outside reset
   a_r10_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (viol_sticky_o & $past(viol_sticky_o)) == $past(viol_sticky_o));

   // R10: every live flag is mirrored in the sticky copy
   a_r10_flag_in_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (viol_flags_o & ~viol_sticky_o) == 5'd0);

   // R9: a nonzero code goes with the valid pulse
   a_r9_code_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (err_code_o != 3'd0) == viol_valid_o);

   // R9: the code points at the lowest set flag
   a_r9_code_lowest: assert property (@(posedge clk) disable iff (!rst_n)
      viol_valid_o |-> (((viol_flags_o >> (err_code_o - 3'd1)) & 5'd1) == 5'd1)
         && ((viol_flags_o & ((5'd1 << (err_code_o - 3'd1)) - 5'd1)) == 5'd0));

   // R7 and R8: early precharge is only reported for a precharge command
   a_r7_early_needs_pre: assert property (@(posedge clk) disable iff (!rst_n)
      viol_flags_o[4] |-> ($past(cmd_i) == 3'd5));

   // R2, R3 and R5: these flags need a read or write one edge earlier
   a_r2_col_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (viol_flags_o[0] || viol_flags_o[1] || viol_flags_o[3])
         |-> ($past(cmd_i) inside {3'd1, 3'd2, 3'd3, 3'd4}));

   // R1 and R4: idle and spare codes never raise a wrong-type flag
   a_r4_type_not_idle: assert property (@(posedge clk) disable iff (!rst_n)
      viol_flags_o[2] |-> ($past(cmd_i) inside {3'd1, 3'd2, 3'd3, 3'd4, 3'd5}));
endmodule

bind ddr2_burst_guard ddr2_bg_checker chk_i (
   .clk           (clk),
   .rst_n         (rst_n),
   .cmd_i         (cmd_i),
   .viol_valid_o  (viol_valid_o),
   .viol_flags_o  (viol_flags_o),
   .viol_sticky_o (viol_sticky_o),
   .err_code_o    (err_code_o)
);

// File: tb/ddr2_burst_guard_tb_top.sv
module ddr2_burst_guard_tb_top;
   localparam logic [2:0] NOP = 3'd0, RD = 3'd1, RDA = 3'd2, WR = 3'd3, WRA = 3'd4, PRE = 3'd5;
   localparam int NVEC = 42;

   // {cmd, bank, expected flags}; BL8, AL=1, WL=2, tWR=2
   localparam logic [9:0] VEC [NVEC] = '{
      {RD ,2'd0,5'b00000}, {NOP,2'd0,5'b00000}, {RD ,2'd1,5'b00000}, {NOP,2'd0,5'b00000}, // R5 legal gap 2, other bank
      {NOP,2'd0,5'b00000}, {NOP,2'd0,5'b00000}, {PRE,2'd0,5'b00000}, {PRE,2'd1,5'b00000}, // R7 exact boundary
      {RD ,2'd2,5'b00000}, {RD ,2'd2,5'b01000}, {NOP,2'd0,5'b00000}, {PRE,2'd2,5'b10100}, // R5 gap 1, R4 plus R7
      {NOP,2'd0,5'b00000}, {NOP,2'd0,5'b00000}, {PRE,2'd2,5'b00000}, {WR ,2'd3,5'b00000},
      {NOP,2'd0,5'b00000}, {RD ,2'd0,5'b00100}, {NOP,2'd0,5'b00000}, {WRA,2'd1,5'b00100}, // R4 direction
      {NOP,2'd0,5'b00000}, {WR ,2'd2,5'b00001}, {PRE,2'd0,5'b00100}, {WR ,2'd3,5'b00000}, // R3, R4 precharge
      {NOP,2'd0,5'b00000}, {NOP,2'd0,5'b00000}, {NOP,2'd0,5'b00000}, {NOP,2'd0,5'b00000},
      {PRE,2'd2,5'b10000}, {PRE,2'd2,5'b00000}, {PRE,2'd3,5'b10000}, {PRE,2'd3,5'b00000}, // R8 boundaries
      {PRE,2'd1,5'b00000}, {RD ,2'd0,5'b00000}, {NOP,2'd0,5'b00000}, {RDA,2'd1,5'b00000}, // R5 auto-precharge interrupt
      {NOP,2'd0,5'b00000}, {RD ,2'd1,5'b00001}, {NOP,2'd0,5'b00000}, {NOP,2'd0,5'b00000}, // R3
      {NOP,2'd0,5'b00000}, {NOP,2'd0,5'b00000}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  cmd = NOP;
   logic [1:0]  bank = 2'd0;
   logic        cfg_bl8 = 1'b1;
   logic [2:0]  cfg_al = 3'd1, cfg_wl = 3'd2, cfg_twr = 3'd2;
   logic        valid;
   logic [4:0]  flags, sticky;
   logic [2:0]  code;
   logic [15:0] stamp;
   int          n_tests = 0, n_fail = 0, tb_cyc = 0;
   bit          done = 1'b0;

   always #10 clk = ~clk;

   always @(posedge clk) tb_cyc <= rst_n ? tb_cyc + 1 : 0;

   ddr2_burst_guard dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_i(cmd), .bank_i(bank),
      .cfg_bl8_i(cfg_bl8), .cfg_al_i(cfg_al), .cfg_wl_i(cfg_wl), .cfg_twr_i(cfg_twr),
      .viol_valid_o(valid), .viol_flags_o(flags), .viol_sticky_o(sticky),
      .err_code_o(code), .err_stamp_o(stamp)
   );

   task automatic check(input string tag, input string what, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   function automatic int exp_code(input logic [4:0] f);
      for (int i = 0; i < 5; i++) if (f[i]) return i + 1;
      return 0;
   endfunction

   function automatic string tag_of(input logic [4:0] f);
      if (f[0]) return "R3";
      if (f[1]) return "R2";
      if (f[2]) return "R4";
      if (f[3]) return "R5";
      if (f[4]) return "R7_R8";
      return "R6";
   endfunction

   task automatic step(input logic [2:0] c, input logic [1:0] b, input logic [4:0] ef, input string tag);
      cmd = c; bank = b;
      @(posedge clk); @(negedge clk);
      check(tag, "flags", int'(flags), int'(ef));
      check(tag, "valid R9", int'(valid), int'(|ef));
      check(tag, "code R9", int'(code), exp_code(ef));
      if (|ef) check(tag, "stamp R9", int'(stamp), (tb_cyc - 1) & 16'hFFFF);
      cmd = NOP;
   endtask

   task automatic do_reset(input logic bl8, input logic [2:0] al, input logic [2:0] wl, input logic [2:0] twr);
      @(negedge clk);
      rst_n = 1'b0; cmd = NOP; cfg_bl8 = bl8; cfg_al = al; cfg_wl = wl; cfg_twr = twr;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
   end

   initial begin
      do_reset(1'b1, 3'd1, 3'd2, 3'd2);
      // R10 reset state
      check("R10", "flags after reset", int'(flags), 0);
      check("R10", "sticky after reset", int'(sticky), 0);
      check("R10", "code after reset", int'(code), 0);
      check("R10", "valid after reset", int'(valid), 0);
      check("R10", "stamp after reset", int'(stamp), 0);

      for (int i = 0; i < NVEC; i++)
         step(VEC[i][9:7], VEC[i][6:5], VEC[i][4:0], tag_of(VEC[i][4:0]));
      check("R10", "sticky after BL8 walk", int'(sticky), 5'b11101);

      // BL4, AL=0, WL=1, tWR=1
      do_reset(1'b0, 3'd0, 3'd1, 3'd1);
      check("R10", "sticky cleared by reset", int'(sticky), 0);
      step(RD , 2'd0, 5'b00000, "R6");
      step(RD , 2'd2, 5'b00010, "R2");    // bank has no effect
      step(NOP, 2'd0, 5'b00000, "R1");
      step(WR , 2'd1, 5'b00000, "R6");    // window of two has expired
      step(PRE, 2'd1, 5'b10000, "R8");    // no type check in BL4
      step(WRA, 2'd2, 5'b00000, "R6");
      step(RD , 2'd2, 5'b00001, "R3");    // auto-precharge wins over BL4 rule
      step(PRE, 2'd1, 5'b00000, "R8");    // write hold of four clocks over
      cfg_bl8 = 1'b1;                     // not in reset: ignored
      step(RD , 2'd3, 5'b00000, "R10");
      step(RD , 2'd3, 5'b00010, "R10");   // still BL4 behaviour
      step(3'd7, 2'd3, 5'b00000, "R1");   // spare codes inside a burst
      step(3'd6, 2'd3, 5'b00000, "R1");
      check("R10", "sticky after BL4 run", int'(sticky), 5'b10011);
      finish_run();
   end
endmodule